// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a shift register of parameterised width (eight stages by default). It either captures a whole word from its parallel inputs or moves its contents one stage toward the last stage, which drives a true serial output and its complement. It runs on one fast system clock. The external shift clock, the active-low clock enable and the active-low load arrive already synchronised, as level inputs sampled on each system clock edge.

The shift clock is combined with the enable by a logical OR to form an effective shift clock. A shift happens in a system cycle in which this effective clock is high and was low in the previous cycle. The enable therefore inhibits shifting while it is high, and raising it while the shift clock is low produces a shift edge of its own. Load has priority over shifting. Registers chain into longer parallel-to-serial converters: one instance's true output feeds the next instance's serial input, and all instances share the shift clock, enable and load.

Top module: `piso_shreg`

## Requirements
- R1: While `rst` is high at a clock edge, all stages become 0 (`tail`=0, `tail_n`=1) and the stored previous effective-clock level becomes 1, so that leaving reset with `shift_clk` high does not shift.
- R2: At each clock edge where `load_n` is 0, stage i takes `par_in[i]` for every i. `par_in[WIDTH-1]` is the last stage.
- R3: When a shift occurs, stage i+1 takes the old stage i, so `tail` shows the old stage WIDTH-2.
- R4: When a shift occurs, stage 0 takes `ser_in`.
- R5: `tail` equals the last stage, and `tail_n` is always its complement.
- R6: While `clk_en_n` stays 1, toggling `shift_clk` changes no stage.
- R7: A 0-to-1 change of `clk_en_n` while `shift_clk` is 0 produces one shift. The same change while `shift_clk` is 1 produces none.
- R8: An effective-clock rise in a cycle where `load_n` is 0 loads and does not shift. The previous level is still updated, so no shift follows when `load_n` is released.
- R9: Releasing `load_n` while `shift_clk` and `clk_en_n` are both 0 causes no shift.
- R10: Two instances chained `tail` to `ser_in` behave as one register of twice the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load, active low |
| par_in | input | WIDTH | Parallel data; bit i goes to stage i |
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Synchronised external shift clock |
| clk_en_n | input | 1 | Shift clock enable, active low |
| tail | output | 1 | Last stage |
| tail_n | output | 1 | Complement of last stage |

## Verification
The bench builds two instances with the default width of eight and chains them into a sixteen-stage converter. Because eight stages give only 256 load patterns, every byte value is loaded into the first instance and its complement into the second. Each value is then shifted out bit by bit, which checks the ordering of both instances and the hand-off across the chain for the whole value space. Directed sequences on shift clock, enable and load then cover the enable-created edge, the inhibit, the priority of load and the release of reset and load.

// File: rtl/piso_pkg.sv
package piso_pkg;
  // Effective shift clock: the enable (active low) forces the level high.
  function automatic logic eff_level(input logic sclk, input logic en_n);
    return sclk | en_n;
  endfunction

  // Rising edge of the effective clock between two samples.
  function automatic logic is_rise(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction
endpackage

// File: rtl/piso_edge_det.sv
module piso_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  import piso_pkg::*;

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= level;
  end

  assign rise = is_rise(level, prev_q);
endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] par,
  input  logic             ser,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] shifted;

  assign shifted[0] = ser;
  for (genvar i = 1; i < WIDTH; i++) begin : g_link
    assign shifted[i] = q_r[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst)        q_r <= '0;
    else if (load)  q_r <= par;
    else if (shift) q_r <= shifted;
  end

  assign q = q_r;
endmodule

// File: rtl/piso_shreg.sv
module piso_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  input  logic             shift_clk,
  input  logic             clk_en_n,
  output logic             tail,
  output logic             tail_n
);
  import piso_pkg::*;

  localparam int LAST = WIDTH - 1;

  logic             eff_now;
  logic             eff_rise;
  logic             load_evt;
  logic             shift_evt;
  logic [WIDTH-1:0] stages;

  assign eff_now   = eff_level(shift_clk, clk_en_n);
  assign load_evt  = ~load_n;
  assign shift_evt = eff_rise & load_n;

  piso_edge_det u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (eff_now),
    .rise  (eff_rise)
  );

  piso_stages #(.WIDTH(WIDTH)) u_stages (
    .clk   (clk),
    .rst   (rst),
    .load  (load_evt),
    .shift (shift_evt),
    .par   (par_in),
    .ser   (ser_in),
    .q     (stages)
  );

  assign tail   = stages[LAST];
  assign tail_n = ~stages[LAST];
endmodule

// File: rtl/piso_shreg_chk.sv
module piso_shreg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load_n,
  input logic [WIDTH-1:0] par_in,
  input logic             ser_in,
  input logic             clk_en_n,
  input logic             shift_evt,
  input logic [WIDTH-1:0] stages,
  input logic             tail,
  input logic             tail_n
);
  // R1: reset clears every stage
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (stages == '0));

  // R2: a low load captures the parallel word
  a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> (stages == $past(par_in)));

  // R3, R4: a shift moves stages up and takes the serial bit into stage 0
  a_r3_shift_order: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> (stages == {$past(stages[WIDTH-2:0]), $past(ser_in)}));

  // R6: enable held high across two cycles leaves stages unchanged
  a_r6_inhibit_hold: assert property (@(posedge clk) disable iff (rst)
    (load_n && clk_en_n && $past(clk_en_n)) |=> $stable(stages));

  // R5: the two outputs never agree
  a_r5_complement: assert property (@(posedge clk) disable iff (rst)
    tail != tail_n);
endmodule

bind piso_shreg piso_shreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load_n    (load_n),
  .par_in    (par_in),
  .ser_in    (ser_in),
  .clk_en_n  (clk_en_n),
  .shift_evt (shift_evt),
  .stages    (stages),
  .tail      (tail),
  .tail_n    (tail_n)
);

// File: tb/piso_shreg_test.sv
module piso_shreg_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_n = 1'b1;
  logic [W-1:0] par_a = '0;
  logic [W-1:0] par_b = '0;
  logic         ser_in = 1'b0;
  logic         shift_clk = 1'b0;
  logic         clk_en_n = 1'b0;
  logic         tail_a, tail_a_n, tail_b, tail_b_n;

  int compared = 0;
  int mismatched = 0;
  logic [2*W-1:0] model = '0;

  always #10ns clk = ~clk;

  piso_shreg #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .load_n(load_n), .par_in(par_a), .ser_in(ser_in),
    .shift_clk(shift_clk), .clk_en_n(clk_en_n), .tail(tail_a), .tail_n(tail_a_n)
  );

  piso_shreg #(.WIDTH(W)) u_next (
    .clk(clk), .rst(rst), .load_n(load_n), .par_in(par_b), .ser_in(tail_a),
    .shift_clk(shift_clk), .clk_en_n(clk_en_n), .tail(tail_b), .tail_n(tail_b_n)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " tail"}, tail_a, model[W-1]);
    chk({tag, " R5 tail_n"}, tail_a_n, ~model[W-1]);
    chk({tag, " R10 chained tail"}, tail_b, model[2*W-1]);
    chk({tag, " R5 chained tail_n"}, tail_b_n, ~model[2*W-1]);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2*W-1:0] shifted(input logic [2*W-1:0] m, input logic b);
    return {m[2*W-2:0], b};
  endfunction

  task automatic load_both(input logic [W-1:0] a, input logic [W-1:0] b);
    load_n = 1'b0; par_a = a; par_b = b;
    step();
    model = {b, a};
    check_all("R2 load");
    load_n = 1'b1;
    step();
    check_all("R9 load release no shift");
  endtask

  task automatic shift_pulse(input logic b, input string tag);
    ser_in = b; shift_clk = 1'b1;
    step();
    model = shifted(model, b);
    check_all(tag);
    shift_clk = 1'b0;
    step();
    check_all({tag, " falling edge idle"});
  endtask

  initial begin
    // R1: leave reset with shift_clk high and ser_in high; no spurious shift
    shift_clk = 1'b1; ser_in = 1'b1;
    step(); step();
    check_all("R1 in reset");
    rst = 1'b0;
    step();
    check_all("R1 after reset");
    shift_clk = 1'b0;
    step();
    check_all("R1 clock low");

    // R2, R3, R4, R10: every byte loaded, then shifted fully through
    for (int v = 0; v < 256; v++) begin
      load_both(W'(v), ~W'(v));
      for (int i = 0; i < W; i++) begin
        shift_pulse(v[i] ^ v[(i+3)%W], "R3 R4 shift");
      end
    end

    // R6: enable high; raising it with clock low makes one shift (R7)
    load_both(8'hA5, 8'h3C);
    ser_in = 1'b1;
    clk_en_n = 1'b1;
    step();
    model = shifted(model, 1'b1);
    check_all("R7 enable rise clock low shifts");
    for (int k = 0; k < 4; k++) begin
      shift_clk = ~shift_clk; ser_in = ~ser_in;
      step();
      check_all("R6 inhibited");
    end
    clk_en_n = 1'b0;
    step();
    check_all("R6 enable fall no shift");

    // R7: enable rise while clock high makes no shift
    ser_in = 1'b0; shift_clk = 1'b1;
    step();
    model = shifted(model, 1'b0);
    check_all("R7 normal shift");
    clk_en_n = 1'b1; ser_in = 1'b1;
    step();
    check_all("R7 enable rise clock high no shift");
    shift_clk = 1'b0;
    step();
    clk_en_n = 1'b0;
    step();
    check_all("R7 return idle");

    // R8: load and effective edge in the same cycle
    load_n = 1'b0; par_a = 8'h81; par_b = 8'h7E; shift_clk = 1'b1; ser_in = 1'b1;
    step();
    model = {8'h7E, 8'h81};
    check_all("R8 load wins");
    load_n = 1'b1;
    step();
    check_all("R8 no late shift");
    shift_clk = 1'b0;
    step();
    shift_pulse(1'b1, "R8 shift after");
    for (int i = 0; i < 2*W; i++) shift_pulse(i[0], "R10 drain");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule